// File: doc/BRIEF.md
# Byte-Wide Timing Register Load Controller

This block sits between a slow host bus and a bank of nineteen 16-bit timing registers. The host presents one byte at a time on an 8-bit bus and strobes each transfer with a falling edge on an active-low load pin. A mode pin says whether the byte is an address or data. A byte-select pin qualifies the byte. The block produces a one-cycle write command that carries a register index and a full 16-bit value. The register bank takes this command at the next clock edge.

Two ways of addressing are offered. In manual mode the host names the target register before its data bytes. It then sends the low and high bytes, each tagged by the byte-select pin. In auto mode the host names only a starting register. It then streams low/high byte pairs. After each pair the target index moves on by one. When it passes the last register it returns to the starting register, not to zero. A start at or beyond the last register pins the index there. A register value is always written as one complete word when its high byte arrives, so a half-updated value is never presented.

The load pin is asynchronous to the block clock. The mode, byte-select and data pins must be held stable from before the falling edge of the load pin until at least four clocks after it. The write port has no ready signal, so the register bank cannot apply back-pressure. Every write command is taken in the cycle it is shown, and the host pacing is the only flow control.

Top module: `regload_ctrl`

## Requirements
- R1: After reset no write is issued, the block is in manual mode, the current index is 0 and the staged low byte is 0.
- R2: Each falling edge of `load_n` causes exactly one transfer, acted on within four clocks. A rising edge of `load_n` causes nothing.
- R3: A transfer with `addr_sel`=0 and `byte_sel`=0 selects manual mode and latches `din[4:0]` as the target index. It issues no write.
- R4: In manual mode a data transfer (`addr_sel`=1) with `byte_sel`=0 stages the byte as the low half and issues no write.
- R5: In manual mode a data transfer with `byte_sel`=1 writes {din, staged low byte} to the latched index. The index does not change, so repeated writes hit the same register.
- R6: A transfer with `addr_sel`=0 and `byte_sel`=1 arms auto mode, taking `din[4:0]` as both start and current index. It issues no write until data transfers follow.
- R7: In auto mode data transfers alternate low then high, starting with low after arming. `byte_sel` is ignored. Only the high transfer writes {high, low}.
- R8: In auto mode each write is followed by the index advancing by one while it is below 18.
- R9: In auto mode a write to index 18 returns the index to the start value. From start 15 the sequence is 15, 16, 17, 18, 15, 16.
- R10: In auto mode a start value of 18 or above makes every write target that same index.
- R11: An address transfer with `byte_sel`=0 given during auto mode returns the block to manual mode.
- R12: `wr_valid` is high for exactly one clock per write. An address transfer never produces a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_n | input | 1 | Asynchronous transfer strobe, acted on at its falling edge |
| addr_sel | input | 1 | 0: byte is an address, 1: byte is data |
| byte_sel | input | 1 | Address transfer: 1 arms auto mode, 0 manual. Manual data transfer: 1 high byte, 0 low byte |
| din | input | 8 | Host byte |
| wr_valid | output | 1 | One-cycle write command, no back-pressure |
| wr_idx | output | 5 | Target register index of the write |
| wr_data | output | 16 | Assembled register value {high, low} |

## Verification
A wrong index counter shows at the ports on the very next write. `wr_idx` then breaks the expected 15, 16, 17, 18, 15 pattern, or fails to stick on a high start. A lost or extra auto byte phase makes the next write carry swapped halves in `wr_data`, or makes it appear one transfer early. A stale staged low byte shows as a wrong low half on the following high-byte write. Every internal fault therefore reaches the write port within one or two transfers, which is about ten clocks at the bench pacing.

// File: rtl/regload_pkg.sv
package regload_pkg;
  localparam int NUM_REGS    = 19;
  localparam int BYTE_W      = 8;
  localparam int REG_W       = 2 * BYTE_W;
  localparam int IDX_W       = $clog2(NUM_REGS);
  localparam int LAST_IDX    = NUM_REGS - 1;
  localparam int SYNC_STAGES = 2;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [REG_W-1:0]  word_t;

  typedef enum logic {
    MODE_MANUAL = 1'b0,
    MODE_AUTO   = 1'b1
  } addr_mode_e;
endpackage

// File: rtl/regload_sync.sv
module regload_sync #(
  parameter int STAGES = regload_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_n,
  output logic strobe
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= load_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], load_n};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign strobe = prev_q & ~sync_q[STAGES-1];

  // R2: a single falling edge yields a single strobe
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

// File: rtl/regload_seq.sv
module regload_seq
  import regload_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  strobe,
  input  logic  addr_sel,
  input  logic  byte_sel,
  input  byte_t din,
  output logic  stage_lo,
  output logic  commit,
  output idx_t  cur_idx
);
  addr_mode_e mode_q;
  idx_t       start_q;
  logic       hi_phase_q;
  logic       data_cyc;
  logic       want_hi;

  assign data_cyc = strobe & addr_sel;
  assign want_hi  = (mode_q == MODE_AUTO) ? hi_phase_q : byte_sel;
  assign stage_lo = data_cyc & ~want_hi;
  assign commit   = data_cyc &  want_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_MANUAL;
      start_q    <= '0;
      cur_idx    <= '0;
      hi_phase_q <= 1'b0;
    end else if (strobe && !addr_sel) begin
      mode_q     <= byte_sel ? MODE_AUTO : MODE_MANUAL;
      start_q    <= din[IDX_W-1:0];
      cur_idx    <= din[IDX_W-1:0];
      hi_phase_q <= 1'b0;
    end else if (data_cyc && mode_q == MODE_AUTO) begin
      hi_phase_q <= ~hi_phase_q;
      if (hi_phase_q) begin
        if (cur_idx >= idx_t'(LAST_IDX)) cur_idx <= start_q;
        else                             cur_idx <= idx_t'(cur_idx + 1'b1);
      end
    end
  end

  // R8: auto write below the last index advances by one
  p_auto_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && mode_q == MODE_AUTO && cur_idx < idx_t'(LAST_IDX))
      |=> cur_idx == idx_t'($past(cur_idx) + 1'b1));
  // R9: auto write at or past the last index returns to the start
  p_auto_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && mode_q == MODE_AUTO && cur_idx >= idx_t'(LAST_IDX))
      |=> cur_idx == $past(start_q));
  // R5: a manual write leaves the index alone
  p_manual_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_cyc && mode_q == MODE_MANUAL) |=> $stable(cur_idx));
endmodule

// File: rtl/regload_assemble.sv
module regload_assemble
  import regload_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  stage_lo,
  input  logic  commit,
  input  idx_t  cur_idx,
  input  byte_t din,
  output logic  wr_valid,
  output idx_t  wr_idx,
  output word_t wr_data
);
  byte_t lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= '0;
      wr_valid <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= commit;
      if (stage_lo) lo_q <= din;
      if (commit) begin
        wr_idx  <= cur_idx;
        wr_data <= {din, lo_q};
      end
    end
  end

  // R12: write commands are single-cycle pulses
  p_write_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // R4: staging a low byte never emits a write
  p_low_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_lo && !commit) |=> !wr_valid);
endmodule

// File: rtl/regload_ctrl.sv
module regload_ctrl
  import regload_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_n,
  input  logic        addr_sel,
  input  logic        byte_sel,
  input  logic [7:0]  din,
  output logic        wr_valid,
  output logic [4:0]  wr_idx,
  output logic [15:0] wr_data
);
  logic strobe;
  logic stage_lo;
  logic commit;
  idx_t cur_idx;

  regload_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_n (load_n),
    .strobe (strobe)
  );

  regload_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .addr_sel (addr_sel),
    .byte_sel (byte_sel),
    .din      (din),
    .stage_lo (stage_lo),
    .commit   (commit),
    .cur_idx  (cur_idx)
  );

  regload_assemble u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .stage_lo (stage_lo),
    .commit   (commit),
    .cur_idx  (cur_idx),
    .din      (din),
    .wr_valid (wr_valid),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data)
  );

  // R12/R3: an address transfer is never followed by a write
  p_addr_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !addr_sel) |=> !wr_valid);
endmodule

// File: tb/regload_ctrl_bench.sv
module regload_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_n = 1'b1;
  logic        addr_sel = 1'b0;
  logic        byte_sel = 1'b0;
  logic [7:0]  din = 8'h00;
  logic        wr_valid;
  logic [4:0]  wr_idx;
  logic [15:0] wr_data;

  int n_tests = 0;
  int n_fail  = 0;
  int n_wr    = 0;
  logic [4:0]  log_idx [0:255];
  logic [15:0] log_dat [0:255];
  bit done = 0;

  always #2 clk = ~clk;

  regload_ctrl u_regload_ctrl (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .addr_sel(addr_sel),
    .byte_sel(byte_sel), .din(din), .wr_valid(wr_valid),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (rst_n && wr_valid && n_wr < 256) begin
      log_idx[n_wr] = wr_idx;
      log_dat[n_wr] = wr_data;
      n_wr = n_wr + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic a, input logic b, input logic [7:0] d);
    @(negedge clk);
    addr_sel = a; byte_sel = b; din = d;
    load_n = 1'b0;
    repeat (4) @(negedge clk);
    load_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 wr_valid", {31'd0, wr_valid}, 0);
    chk("R1 wr_idx", {27'd0, wr_idx}, 0);
    chk("R1 wr_data", {16'd0, wr_data}, 0);
    // stage-free high write in manual mode exposes index 0 and low byte 0
    begin
      int base = n_wr;
      xfer(1, 1, 8'h5A);
      chk("R1 manual default write count", n_wr - base, 1);
      chk("R1 default index", {27'd0, log_idx[base]}, 0);
      chk("R1 default low byte", {16'd0, log_dat[base]}, 32'h5A00);
    end
  endtask

  task automatic t_manual();
    int base = n_wr;
    xfer(0, 0, 8'd7);
    chk("R3 address gives no write", n_wr - base, 0);
    xfer(1, 0, 8'h34);
    chk("R4 low byte gives no write", n_wr - base, 0);
    xfer(1, 1, 8'h12);
    chk("R5 manual write count", n_wr - base, 1);
    chk("R5 manual index", {27'd0, log_idx[base]}, 7);
    chk("R5 manual data", {16'd0, log_dat[base]}, 32'h1234);
    xfer(1, 1, 8'h99);
    chk("R5 no increment", {27'd0, log_idx[base+1]}, 7);
    chk("R5 low byte reused", {16'd0, log_dat[base+1]}, 32'h9934);
  endtask

  task automatic t_rise_only();
    int base = n_wr;
    @(negedge clk);
    addr_sel = 1; byte_sel = 1; din = 8'hEE;
    load_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R2 idle load pin gives no write", n_wr - base, 0);
  endtask

  task automatic t_auto_full();
    int base = n_wr;
    xfer(0, 1, 8'd0);
    chk("R6 arming gives no write", n_wr - base, 0);
    for (int k = 0; k < 19; k++) begin
      xfer(1, k[0], 8'(k));
      xfer(1, ~k[0], 8'(8'h80 + k));
    end
    chk("R7 auto write count", n_wr - base, 19);
    for (int k = 0; k < 19; k++) begin
      chk("R8 auto index", {27'd0, log_idx[base+k]}, 32'(k));
      chk("R7 auto data", {16'd0, log_dat[base+k]}, 32'((8'h80 + k) * 256 + k));
    end
  endtask

  task automatic t_auto_wrap();
    int base = n_wr;
    int exp_idx [0:5] = '{15, 16, 17, 18, 15, 16};
    xfer(0, 1, 8'd15);
    for (int k = 0; k < 6; k++) begin
      xfer(1, 1, 8'(8'h40 + k));
      chk("R7 low phase silent", n_wr - base, k);
      xfer(1, 0, 8'(8'hC0 + k));
    end
    chk("R9 wrap write count", n_wr - base, 6);
    for (int k = 0; k < 6; k++) begin
      chk("R9 wrap index", {27'd0, log_idx[base+k]}, 32'(exp_idx[k]));
      chk("R9 wrap data", {16'd0, log_dat[base+k]}, 32'((8'hC0 + k) * 256 + 8'h40 + k));
    end
  endtask

  task automatic t_auto_stick(input logic [7:0] s);
    int base = n_wr;
    xfer(0, 1, s);
    for (int k = 0; k < 3; k++) begin
      xfer(1, 0, 8'(k));
      xfer(1, 1, 8'(8'h20 + k));
    end
    chk("R10 stick write count", n_wr - base, 3);
    for (int k = 0; k < 3; k++)
      chk("R10 stick index", {27'd0, log_idx[base+k]}, {27'd0, s[4:0]});
  endtask

  task automatic t_back_manual();
    int base = n_wr;
    xfer(0, 1, 8'd3);
    xfer(1, 0, 8'h11);
    xfer(1, 1, 8'h22);
    xfer(0, 0, 8'd9);
    xfer(1, 1, 8'h77);
    chk("R11 write count", n_wr - base, 2);
    chk("R11 auto part index", {27'd0, log_idx[base]}, 3);
    chk("R11 manual index", {27'd0, log_idx[base+1]}, 9);
    chk("R11 manual data", {16'd0, log_dat[base+1]}, 32'h7711);
    xfer(1, 1, 8'h78);
    chk("R11 manual holds index", {27'd0, log_idx[base+2]}, 9);
  endtask

  task automatic t_pulse();
    int hi_cycles = 0;
    xfer(0, 0, 8'd2);
    @(negedge clk);
    addr_sel = 1; byte_sel = 1; din = 8'h01;
    load_n = 1'b0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (wr_valid) hi_cycles++;
    end
    load_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 pulse width", hi_cycles, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_manual();
    t_rise_only();
    t_auto_full();
    t_auto_wrap();
    t_auto_stick(8'd18);
    t_auto_stick(8'd25);
    t_back_manual();
    t_pulse();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule